// File: doc/BRIEF.md
# Flash Word Program Status Engine

This block models the internal write cycle of a 16-bit parallel flash array together with the status that the array reports while that cycle runs. A command front end, which is outside this block, delivers an already unlocked request as a one-cycle strobe. The strobe selects either a word program, which carries an address and data, or an erase of the whole array. The engine then raises a busy flag and counts down an internal timer sized in clock cycles. When the timer expires, it commits the result to a small register array and returns to normal reading.

While the cycle runs, the read port does not return plain array contents. Each byte lane instead carries two status bits. The most significant bit of the lane is a polling bit: it holds the complement of the pending data during a program and reads 0 during an erase. The bit just below it is a toggle bit, which changes on every read strobe taken while busy. The remaining bits still show the stored word at the address being read. Software can therefore detect completion by watching either status bit settle.

Top module: `flash_pgm_status`

## Requirements
- R1: After reset, busy is 0 and every word reads as 16'hFFFF.
- R2: A program to address A stores the old word at A ANDed with the write data, so no stored bit ever goes from 0 to 1.
- R3: An erase sets every word of the array to 16'hFFFF.
- R4: busy is high for exactly PGM_CYCLES clock cycles after an accepted program and ERASE_CYCLES cycles after an accepted erase, counted from the clock edge that takes the strobe.
- R5: While a program is busy, rd_data bits 15 and 7 read as the complement of bits 15 and 7 of the pending write data.
- R6: While an erase is busy, rd_data bits 15 and 7 read as 0.
- R7: While busy, rd_data bits 14 and 6 both show a toggle state that inverts at each clock edge where rd_en is high; the state is 0 after reset.
- R8: Read strobes taken while idle leave the toggle state unchanged, and idle reads return the true stored word on all 16 bits.
- R9: Program or erase strobes that arrive while busy are ignored: the running cycle keeps its length and target, and no extra write takes place.
- R10: While busy, rd_data bits 13:8 and 5:0 show the stored word at rd_addr as it was before the running cycle commits.
- R11: If both strobes are raised in the same idle cycle, the erase is taken and the program is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_pgm | input | 1 | Request to program one word |
| start_erase | input | 1 | Request to erase the whole array |
| wr_addr | input | ADDR_W | Word address of a program request |
| wr_data | input | 16 | Data of a program request |
| rd_en | input | 1 | Read strobe; advances the toggle bit while busy |
| rd_addr | input | ADDR_W | Word address to read |
| rd_data | output | 16 | Stored word, or the status word while busy |
| busy | output | 1 | Program or erase cycle in progress |

## Verification
The hardest situation to reach is a second request landing in the middle of a running cycle, combined with the toggle bit's history across idle reads. A toggle bit that wrongly flipped during idle time shows only in a later cycle's first status read. The stimulus therefore does idle reads between cycles and, inside chosen cycles, raises both strobes with a different address and all-zero data. It reads on every busy cycle, so the expected toggle value follows a running count of busy reads. The bench then checks the untouched neighbour word and the exact busy length.

// File: rtl/flash_pgm_pkg.sv
`timescale 1ns/1ps
package flash_pgm_pkg;
  localparam int WORD_W = 16;
  localparam int LANES  = WORD_W / 8;

  // Programming can only clear bits.
  function automatic logic [WORD_W-1:0] pgm_merge(input logic [WORD_W-1:0] old_w,
                                                  input logic [WORD_W-1:0] new_w);
    return old_w & new_w;
  endfunction

  // Status word returned while a cycle runs.
  function automatic logic [WORD_W-1:0] status_word(input logic [WORD_W-1:0] arr_w,
                                                    input logic [WORD_W-1:0] pend_w,
                                                    input logic              erasing,
                                                    input logic              tog);
    logic [WORD_W-1:0] w;
    w = arr_w;
    for (int l = 0; l < LANES; l++) begin
      w[8*l+7] = erasing ? 1'b0 : ~pend_w[8*l+7];
      w[8*l+6] = tog;
    end
    return w;
  endfunction
endpackage

// File: rtl/fps_timer.sv
`timescale 1ns/1ps
module fps_timer #(
  parameter int PGM_CYCLES   = 6,
  parameter int ERASE_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic launch_erase,
  output logic busy,
  output logic erasing,
  output logic done
);
  localparam int MAXC  = (PGM_CYCLES > ERASE_CYCLES) ? PGM_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      erasing <= 1'b0;
      cnt     <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      erasing <= launch_erase;
      cnt     <= launch_erase ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PGM_CYCLES - 1);
    end else if (done) begin
      busy    <= 1'b0;
      erasing <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R4: the cycle ends right after the count reaches zero
  a_r4_ends_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == '0 && !launch) |=> !busy);
  // R4: the count steps down by one each busy cycle
  a_r4_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));
  // R9: a launch never lands on a running cycle
  a_r9_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
endmodule

// File: rtl/fps_array.sv
`timescale 1ns/1ps
module fps_array
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_pgm,
  input  logic              commit_erase,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  word_ones;
  logic [WORD_W-1:0] target_word;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '1;
      else if (commit_erase)
        word_q <= '1;
      else if (commit_pgm && wr_addr == ADDR_W'(i))
        word_q <= pgm_merge(word_q, wr_data);
    end
    assign mem[i]       = word_q;
    assign word_ones[i] = &word_q;
  end

  assign rd_word     = mem[rd_addr];
  assign target_word = mem[wr_addr];

  // R2: a program commit never raises a stored bit
  a_r2_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pgm |=> ((mem[$past(wr_addr)] & ~$past(target_word)) == '0));
  // R3: after an erase commit every word is all ones
  a_r3_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    commit_erase |=> (&word_ones));
  // R2: one commit kind at a time
  a_r2_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_pgm && commit_erase));
endmodule

// File: rtl/fps_status.sv
`timescale 1ns/1ps
module fps_status
  import flash_pgm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              erasing,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] arr_word,
  input  logic [WORD_W-1:0] pend_data,
  output logic [WORD_W-1:0] rd_data
);
  logic tog_q;
  logic tog_step;

  assign tog_step = busy && rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tog_q <= 1'b0;
    else if (tog_step)
      tog_q <= ~tog_q;
  end

  assign rd_data = busy ? status_word(arr_word, pend_data, erasing, tog_q) : arr_word;

  // R7: every busy read strobe inverts the toggle state
  a_r7_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (tog_q != $past(tog_q)));
  // R8: idle reads leave the toggle state alone
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tog_q));
  // R8: idle reads return the stored word
  a_r8_true_data: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_data == arr_word));
endmodule

// File: rtl/flash_pgm_status.sv
`timescale 1ns/1ps
module flash_pgm_status
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int PGM_CYCLES   = 6,
  parameter int ERASE_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pgm,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              busy
);
  logic              accept;
  logic              accept_erase;
  logic              erasing;
  logic              done;
  logic              commit_pgm;
  logic              commit_erase;
  logic [ADDR_W-1:0] pend_addr;
  logic [WORD_W-1:0] pend_data;
  logic [WORD_W-1:0] arr_word;

  assign accept       = !busy && (start_pgm || start_erase);
  assign accept_erase = accept && start_erase;   // erase wins a tie
  assign commit_pgm   = done && !erasing;
  assign commit_erase = done && erasing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr <= '0;
      pend_data <= '1;
    end else if (accept) begin
      pend_addr <= wr_addr;
      pend_data <= accept_erase ? '1 : wr_data;
    end
  end

  fps_timer #(
    .PGM_CYCLES  (PGM_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (accept),
    .launch_erase(accept_erase),
    .busy        (busy),
    .erasing     (erasing),
    .done        (done)
  );

  fps_array #(.ADDR_W(ADDR_W)) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_pgm  (commit_pgm),
    .commit_erase(commit_erase),
    .wr_addr     (pend_addr),
    .wr_data     (pend_data),
    .rd_addr     (rd_addr),
    .rd_word     (arr_word)
  );

  fps_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .erasing  (erasing),
    .rd_en    (rd_en),
    .arr_word (arr_word),
    .pend_data(pend_data),
    .rd_data  (rd_data)
  );

  // R9: requests during a cycle do not touch the pending target
  a_r9_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(pend_addr) && $stable(pend_data)));
  // R11: a tied request becomes an erase
  a_r11_erase_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_pgm && start_erase) |=> (busy && erasing));
  // R6: erase polling bits read zero
  a_r6_poll_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erasing) |-> (rd_data[15] == 1'b0 && rd_data[7] == 1'b0));
  // R10: non-status bits follow the array while busy
  a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((rd_data & 16'h3F3F) == (arr_word & 16'h3F3F)));
endmodule

// File: tb/test_flash_pgm_status.sv
`timescale 1ns/1ps
module test_flash_pgm_status;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int PGM   = 6;
  localparam int ERS   = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_pgm = 1'b0;
  logic          start_erase = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic          busy;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] model [DEPTH];
  logic        exp_tog = 1'b0;

  always #2 clk = ~clk;

  flash_pgm_status #(.ADDR_W(AW), .PGM_CYCLES(PGM), .ERASE_CYCLES(ERS)) i_flash_pgm_status (
    .clk(clk), .rst_n(rst_n), .start_pgm(start_pgm), .start_erase(start_erase),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status(input logic [15:0] arr, input logic [15:0] d,
                                             input bit ers, input logic t);
    logic [15:0] poll;
    poll = ers ? 16'h0000 : (~d & 16'h8080);
    return (arr & 16'h3F3F) | poll | (t ? 16'h4040 : 16'h0000);
  endfunction

  task automatic idle_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1;
    chk(req, {16'h0, rd_data}, {16'h0, model[a]});
  endtask

  task automatic run_op(input bit ers, input bit both, input logic [AW-1:0] a,
                        input logic [15:0] d, input bit inject);
    int n;
    logic [AW-1:0] ra;
    n = 0;
    @(negedge clk);
    start_pgm = !ers || both; start_erase = ers; wr_addr = a; wr_data = d;
    @(negedge clk);
    start_pgm = 1'b0; start_erase = 1'b0;
    while (busy && n < 1000) begin
      ra = AW'(a + AW'(n));
      rd_en = 1'b1; rd_addr = ra;
      #1;
      if (ers) chk("R6 R7 R10", {16'h0, rd_data}, {16'h0, exp_status(model[ra], d, 1'b1, exp_tog)});
      else     chk("R5 R7 R10", {16'h0, rd_data}, {16'h0, exp_status(model[ra], d, 1'b0, exp_tog)});
      exp_tog = ~exp_tog;
      if (inject && n == 1) begin
        start_pgm = 1'b1; start_erase = 1'b1; wr_addr = AW'(a + 1'b1); wr_data = 16'h0000;
      end else begin
        start_pgm = 1'b0; start_erase = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    rd_en = 1'b0; start_pgm = 1'b0; start_erase = 1'b0;
    chk("R4 R9 R11", n, ers ? ERS : PGM);
    if (ers) begin
      for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    end else begin
      model[a] = model[a] & d;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    #11 rst_n = 1'b1;
    // R1: reset state
    @(negedge clk); #1;
    chk("R1", {31'h0, busy}, 32'h0);
    for (int i = 0; i < DEPTH; i++) idle_read(AW'(i), "R1 R8");
    // R2 R5: program every word, injecting a late request on one cycle (R9)
    for (int i = 0; i < DEPTH; i++)
      run_op(1'b0, 1'b0, AW'(i), 16'h5A3C ^ 16'(i * 16'h1357), i == 2);
    for (int i = 0; i < DEPTH; i++) idle_read(AW'(i), "R2 R8 R9");
    // R2: second pass, bits may only clear
    for (int i = 0; i < DEPTH; i++)
      run_op(1'b0, 1'b0, AW'(i), ~16'(i * 16'h0421) | 16'h8000, i == 5);
    for (int i = 0; i < DEPTH; i++) idle_read(AW'(i), "R2");
    // R8: extra idle reads must not move the toggle state
    for (int i = 0; i < 5; i++) idle_read(AW'(3), "R8");
    // R3 R6: erase with an injected request
    run_op(1'b1, 1'b0, AW'(0), 16'hFFFF, 1'b1);
    for (int i = 0; i < DEPTH; i++) idle_read(AW'(i), "R3 R9");
    // R2: program zero then FFFF keeps zero
    run_op(1'b0, 1'b0, AW'(4), 16'h0000, 1'b0);
    run_op(1'b0, 1'b0, AW'(4), 16'hFFFF, 1'b0);
    idle_read(AW'(4), "R2");
    // R11: both strobes together give an erase
    run_op(1'b1, 1'b1, AW'(4), 16'h0000, 1'b0);
    for (int i = 0; i < DEPTH; i++) idle_read(AW'(i), "R11 R3");
    @(negedge clk);
    rd_en = 1'b0; #1;
    chk("R4", {31'h0, busy}, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule